// File: doc/BRIEF.md
# Serial interrupt host controller

This block is the host end of a shared, single-wire, open-drain interrupt bus. A bus cycle begins with a Start Frame: the line is held low for a few clocks, driven high for one clock, and then released. A train of three-clock data frames follows. Each frame has a sample clock, a recovery clock and a turnaround clock. Peripherals pull the line low on the sample clock of their slot, and the host records the level of every slot. The cycle ends with a Stop Frame whose low width tells all agents which mode the next cycle runs in. In continuous mode the host starts every cycle. In quiet mode the line rests released until some agent starts a cycle.

The host starts cycles on its own. When a peripheral begins a Start Frame in quiet mode, the host takes it over and stretches the low pulse to the programmed width. The levels from each completed cycle are published together on a parallel vector. The line driver is split into a drive enable and a drive value. The bus level comes back through `line_in`.

The sequencer has six states and moves between them as follows:
- `S_IDLE` goes to `S_START_LOW` when a peripheral start is seen or when the host begins a cycle itself.
- `S_START_LOW` goes to `S_START_HIGH` when its low count runs out.
- `S_START_HIGH` goes to `S_FRAMES` after one clock.
- `S_FRAMES` steps through its phases `PH_SAMPLE`, `PH_RECOVER` and `PH_TURN` on every slot. It goes to `S_STOP_LOW` after the turnaround of the last slot.
- `S_STOP_LOW` goes to `S_STOP_HIGH` when its low count runs out.
- `S_STOP_HIGH` returns to `S_START_LOW` in continuous mode, or to `S_IDLE` in quiet mode.

Top module: `sirq_host`

## Requirements
- R1: While rst_n is low, drv_en is 0 and irq_vec is all zero. The bus comes out of reset in continuous mode, so on the first clock after reset is released the host decides to begin its own Start Frame. It drives the line low from the following clock.
- R2: A Start Frame that the host begins itself keeps the line low (drv_en=1, drv_val=0) for E+1 clocks. E is cfg_start_ext, with the values 0, 1 and 2 treated as 3. The host then drives the line high (drv_en=1, drv_val=1) for exactly one clock and releases it.
- R3: In quiet mode, while idle, line_in reading 0 on a clock is taken as a peripheral's Start Frame. From the next clock the host drives the line low for E clocks, then high for one clock.
- R4: Clock 0 is the clock on which the host drives the line high at the end of the Start pulse. Counting from there, drv_en is 0 on clocks 1 to 3N+1, and slot k (k = 1..N) is sampled on clock 3k-1. A low line at that sample sets irq_vec bit k-1 to 1, and a high line sets it to 0.
- R5: N is cfg_frames as seen on clock 0, with 0 treated as 1 and values above MAX_FRAMES (17) treated as MAX_FRAMES. After that cycle, irq_vec bits at index N and above read 0.
- R6: The Stop Frame starts on clock 3N+2. cfg_quiet is read on the last turnaround clock. If it reads 1 (quiet mode next), the line is driven low for 2 clocks. If it reads 0 (continuous mode next), the line is driven low for 3 clocks. In both cases the line is then driven high for one clock.
- R7: irq_vec changes only at the clock edge that ends the high clock of the Stop Frame, and it keeps its value in all other cycles.
- R8: When the Stop Frame selected continuous mode, the host starts a new Start Frame of E+1 low clocks on the very next clock.
- R9: When the Stop Frame selected quiet mode, the line stays released until one of two things happens. A peripheral start (R3) takes priority. Otherwise, once cfg_quiet reads 0, the host begins its own Start Frame from the next clock.
- R10: Line levels during recovery and turnaround clocks, including clock 1, have no effect on irq_vec.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| line_in | input | 1 | Sampled level of the shared interrupt line |
| drv_en | output | 1 | Host drives the line when 1, releases it when 0 |
| drv_val | output | 1 | Level driven onto the line when drv_en is 1 |
| cfg_quiet | input | 1 | 1 requests quiet mode, 0 requests continuous mode, for the next cycle |
| cfg_start_ext | input | EXT_W (3) | Host low clocks added to the first Start clock, 3 to 7 |
| cfg_frames | input | FW (5) | Number of data frames per cycle |
| irq_vec | output | MAX_FRAMES (17) | Latched level per slot, 1 = asserted; bit k-1 holds slot k |

## Verification
Two sets of events are made to collide.

The first collision is a peripheral start and the end of a cycle. A peripheral start request is raised while a cycle is still running, so it lands on the very first idle clock after a quiet Stop Frame. That is the same clock edge on which the new vector has just been published. The check is that the host takes over on the next clock with an E-clock low pulse while irq_vec holds the freshly published value.

The second collision is line noise and slot sampling. In one cycle a peripheral pulls the line low on every recovery and turnaround clock while the sample clocks carry a sparse pattern. The check is that irq_vec contains only the sampled bits. A cycle-accurate model in the bench compares drive enable, drive value and the vector on every clock.

// File: rtl/sirq_pkg.sv
package sirq_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_START_LOW,
        S_START_HIGH,
        S_FRAMES,
        S_STOP_LOW,
        S_STOP_HIGH
    } sirq_state_e;

    typedef enum logic [1:0] {
        PH_SAMPLE,
        PH_RECOVER,
        PH_TURN
    } sirq_phase_e;

    localparam int STOP_QUIET_LOW = 2;
    localparam int STOP_CONT_LOW  = 3;

endpackage

// File: rtl/sirq_cfg_clamp.sv
module sirq_cfg_clamp #(
    parameter int MAX_FRAMES = 17,
    parameter int FW         = 5,
    parameter int EXT_W      = 3,
    parameter int MIN_EXT    = 3
) (
    input  logic [EXT_W-1:0] cfg_start_ext,
    input  logic [FW-1:0]    cfg_frames,
    output logic [EXT_W-1:0] ext_eff,
    output logic [FW-1:0]    frames_eff
);

    always_comb begin
        if (cfg_start_ext < EXT_W'(MIN_EXT)) begin
            ext_eff = EXT_W'(MIN_EXT);
        end else begin
            ext_eff = cfg_start_ext;
        end

        if (cfg_frames == '0) begin
            frames_eff = FW'(1);
        end else if (cfg_frames > FW'(MAX_FRAMES)) begin
            frames_eff = FW'(MAX_FRAMES);
        end else begin
            frames_eff = cfg_frames;
        end
    end

endmodule

// File: rtl/sirq_seq.sv
module sirq_seq
    import sirq_pkg::*;
#(
    parameter int MAX_FRAMES = 17,
    parameter int FW         = 5,
    parameter int SW         = 5,
    parameter int EXT_W      = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             line_in,
    input  logic             cfg_quiet,
    input  logic [EXT_W-1:0] ext_eff,
    input  logic [FW-1:0]    frames_eff,
    output logic             drv_en,
    output logic             drv_val,
    output logic             sample_en,
    output logic [SW-1:0]    sample_idx,
    output logic             frame_begin,
    output logic             publish
);

    localparam logic [EXT_W-1:0] STOP_Q_REM = EXT_W'(STOP_QUIET_LOW - 1);
    localparam logic [EXT_W-1:0] STOP_C_REM = EXT_W'(STOP_CONT_LOW - 1);

    sirq_state_e      state;
    sirq_phase_e      phase;
    logic [EXT_W-1:0] rem;
    logic [FW-1:0]    slot;
    logic [FW-1:0]    nfr;
    logic             stop_quiet;
    logic             quiet_r;

    // State register and counters
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state      <= S_IDLE;
            phase      <= PH_TURN;
            rem        <= '0;
            slot       <= '0;
            nfr        <= FW'(1);
            stop_quiet <= 1'b0;
            quiet_r    <= 1'b0;
        end else begin
            unique case (state)
                S_IDLE: begin
                    if (!line_in) begin
                        // peripheral drove the first low clock; host adds E
                        state <= S_START_LOW;
                        rem   <= ext_eff - 1'b1;
                    end else if (!quiet_r || !cfg_quiet) begin
                        state <= S_START_LOW;
                        rem   <= ext_eff;
                    end
                end
                S_START_LOW: begin
                    if (rem == '0) begin
                        state <= S_START_HIGH;
                    end else begin
                        rem <= rem - 1'b1;
                    end
                end
                S_START_HIGH: begin
                    state <= S_FRAMES;
                    phase <= PH_TURN;
                    slot  <= '0;
                    nfr   <= frames_eff;
                end
                S_FRAMES: begin
                    unique case (phase)
                        PH_SAMPLE:  phase <= PH_RECOVER;
                        PH_RECOVER: phase <= PH_TURN;
                        PH_TURN: begin
                            if (slot == nfr) begin
                                state      <= S_STOP_LOW;
                                stop_quiet <= cfg_quiet;
                                rem        <= cfg_quiet ? STOP_Q_REM : STOP_C_REM;
                            end else begin
                                phase <= PH_SAMPLE;
                                slot  <= slot + 1'b1;
                            end
                        end
                        default: phase <= PH_TURN;
                    endcase
                end
                S_STOP_LOW: begin
                    if (rem == '0) begin
                        state <= S_STOP_HIGH;
                    end else begin
                        rem <= rem - 1'b1;
                    end
                end
                S_STOP_HIGH: begin
                    quiet_r <= stop_quiet;
                    if (stop_quiet) begin
                        state <= S_IDLE;
                    end else begin
                        state <= S_START_LOW;
                        rem   <= ext_eff;
                    end
                end
                default: state <= S_IDLE;
            endcase
        end
    end

    // Outputs decoded from state
    always_comb begin
        drv_en      = 1'b0;
        drv_val     = 1'b0;
        sample_en   = 1'b0;
        frame_begin = 1'b0;
        publish     = 1'b0;
        unique case (state)
            S_IDLE:       ;
            S_START_LOW:  drv_en = 1'b1;
            S_START_HIGH: begin
                drv_en      = 1'b1;
                drv_val     = 1'b1;
                frame_begin = 1'b1;
            end
            S_FRAMES:     sample_en = (phase == PH_SAMPLE);
            S_STOP_LOW:   drv_en = 1'b1;
            S_STOP_HIGH: begin
                drv_en  = 1'b1;
                drv_val = 1'b1;
                publish = 1'b1;
            end
            default:      ;
        endcase
    end

    assign sample_idx = SW'(slot - 1'b1);

    // Checker state: number of earlier consecutive driven-low clocks
    logic       drv_low;
    logic [3:0] low_run;
    assign drv_low = drv_en && !drv_val;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            low_run <= '0;
        end else if (drv_low) begin
            low_run <= (low_run == 4'hF) ? low_run : low_run + 1'b1;
        end else begin
            low_run <= '0;
        end
    end

    p_low_width_r2: assert property (@(posedge clk) disable iff (!rst_n)
        drv_low |-> (low_run <= 4'd7));

    p_high_follows_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(drv_low) && !drv_low) |-> (drv_en && drv_val));

    p_high_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (drv_en && drv_val) |=> !(drv_en && drv_val));

    p_sample_released_r4: assert property (@(posedge clk) disable iff (!rst_n)
        sample_en |-> !drv_en);

    p_frames_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_FRAMES) |-> (nfr >= FW'(1) && nfr <= FW'(MAX_FRAMES)));

endmodule

// File: rtl/sirq_capture.sv
module sirq_capture #(
    parameter int MAX_FRAMES = 17,
    parameter int SW         = 5
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  line_in,
    input  logic                  sample_en,
    input  logic [SW-1:0]         sample_idx,
    input  logic                  frame_begin,
    input  logic                  publish,
    output logic [MAX_FRAMES-1:0] irq_vec
);

    logic [MAX_FRAMES-1:0] shadow;

    for (genvar i = 0; i < MAX_FRAMES; i++) begin : g_slot
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                shadow[i] <= 1'b0;
            end else if (frame_begin) begin
                shadow[i] <= 1'b0;
            end else if (sample_en && (sample_idx == SW'(i))) begin
                shadow[i] <= ~line_in;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            irq_vec <= '0;
        end else if (publish) begin
            irq_vec <= shadow;
        end
    end

    p_vec_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !publish |=> $stable(irq_vec));

endmodule

// File: rtl/sirq_host.sv
module sirq_host #(
    parameter int MAX_FRAMES = 17,
    parameter int EXT_W      = 3,
    parameter int MIN_EXT    = 3,
    localparam int FW        = $clog2(MAX_FRAMES + 1),
    localparam int SW        = $clog2(MAX_FRAMES)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  line_in,
    output logic                  drv_en,
    output logic                  drv_val,
    input  logic                  cfg_quiet,
    input  logic [EXT_W-1:0]      cfg_start_ext,
    input  logic [FW-1:0]         cfg_frames,
    output logic [MAX_FRAMES-1:0] irq_vec
);

    logic [EXT_W-1:0] ext_eff;
    logic [FW-1:0]    frames_eff;
    logic             sample_en;
    logic [SW-1:0]    sample_idx;
    logic             frame_begin;
    logic             publish;

    sirq_cfg_clamp #(
        .MAX_FRAMES (MAX_FRAMES),
        .FW         (FW),
        .EXT_W      (EXT_W),
        .MIN_EXT    (MIN_EXT)
    ) u_clamp (
        .cfg_start_ext (cfg_start_ext),
        .cfg_frames    (cfg_frames),
        .ext_eff       (ext_eff),
        .frames_eff    (frames_eff)
    );

    sirq_seq #(
        .MAX_FRAMES (MAX_FRAMES),
        .FW         (FW),
        .SW         (SW),
        .EXT_W      (EXT_W)
    ) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .line_in     (line_in),
        .cfg_quiet   (cfg_quiet),
        .ext_eff     (ext_eff),
        .frames_eff  (frames_eff),
        .drv_en      (drv_en),
        .drv_val     (drv_val),
        .sample_en   (sample_en),
        .sample_idx  (sample_idx),
        .frame_begin (frame_begin),
        .publish     (publish)
    );

    sirq_capture #(
        .MAX_FRAMES (MAX_FRAMES),
        .SW         (SW)
    ) u_capture (
        .clk         (clk),
        .rst_n       (rst_n),
        .line_in     (line_in),
        .sample_en   (sample_en),
        .sample_idx  (sample_idx),
        .frame_begin (frame_begin),
        .publish     (publish),
        .irq_vec     (irq_vec)
    );

endmodule

// File: tb/test_sirq_host.sv
module test_sirq_host;

    localparam int MAXF = 17;
    localparam int EW   = 3;
    localparam int FW   = 5;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            cfg_quiet = 1'b0;
    logic [EW-1:0]   cfg_start_ext = 3'd4;
    logic [FW-1:0]   cfg_frames = 5'd17;
    logic            periph_low = 1'b0;
    logic            drv_en;
    logic            drv_val;
    logic [MAXF-1:0] irq_vec;
    wire             line_w;

    always #4 clk = ~clk;

    assign line_w = !((drv_en && !drv_val) || periph_low);

    sirq_host #(.MAX_FRAMES(MAXF), .EXT_W(EW), .MIN_EXT(3)) i_sirq_host (
        .clk           (clk),
        .rst_n         (rst_n),
        .line_in       (line_w),
        .drv_en        (drv_en),
        .drv_val       (drv_val),
        .cfg_quiet     (cfg_quiet),
        .cfg_start_ext (cfg_start_ext),
        .cfg_frames    (cfg_frames),
        .irq_vec       (irq_vec)
    );

    int              total = 0;
    int              bad = 0;
    bit              finished = 0;
    int              cycles_done = 0;
    logic [MAXF-1:0] pattern = 17'h1A5C3;
    logic [MAXF-1:0] model_vec = '0;
    bit              noise = 0;
    bit              req_periph = 0;

    task automatic chk(input string tag, input string what, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h at %0t", tag, what, act, exp, $time);
        end
    endtask

    function automatic int ext_of(input logic [EW-1:0] v);
        return (v < 3) ? 3 : int'(v);
    endfunction

    function automatic int frames_of(input logic [FW-1:0] v);
        if (v == 0) return 1;
        if (v > MAXF) return MAXF;
        return int'(v);
    endfunction

    // one clock of the model: compare at the falling edge, then set the
    // peripheral pull for the rising edge that closes this clock
    task automatic step(input string tag, input bit en, input bit val, input bit pdrive);
        @(negedge clk);
        chk(tag, "drv_en", int'(drv_en), int'(en));
        if (en) chk(tag, "drv_val", int'(drv_val), int'(val));
        chk("R7", "irq_vec", int'(irq_vec), int'(model_vec));
        periph_low = pdrive;
    endtask

    // reference model of the bus protocol
    initial begin : model
        int              e;
        int              n;
        bit              host_start;
        bit              q;
        bit              nz;
        string           ltag;
        logic [MAXF-1:0] pat;
        logic [MAXF-1:0] new_vec;
        @(negedge clk);
        chk("R1", "drv_en in reset", int'(drv_en), 0);
        chk("R1", "irq_vec in reset", int'(irq_vec), 0);
        rst_n = 1'b1;
        e = ext_of(cfg_start_ext);
        host_start = 1;
        ltag = "R1";
        forever begin
            repeat (host_start ? e + 1 : e) step(ltag, 1, 0, 0);
            step("R2", 1, 1, 0);
            n   = frames_of(cfg_frames);
            pat = pattern;
            nz  = noise;
            new_vec = '0;
            step("R4", 0, 0, nz);
            for (int k = 1; k <= n; k++) begin
                step("R4", 0, 0, pat[k-1]);
                new_vec[k-1] = pat[k-1];
                step("R10", 0, 0, nz);
                step("R10", 0, 0, nz);
            end
            q = cfg_quiet;
            repeat (q ? 2 : 3) step("R6", 1, 0, 0);
            step("R6", 1, 1, 0);
            model_vec = new_vec;
            cycles_done++;
            e = ext_of(cfg_start_ext);
            if (!q) begin
                host_start = 1;
                ltag = "R8";
            end else begin
                forever begin
                    step("R9", 0, 0, req_periph);
                    if (periph_low) begin
                        req_periph = 0;
                        host_start = 0;
                        ltag = "R3";
                        break;
                    end
                    if (!cfg_quiet) begin
                        host_start = 1;
                        ltag = "R9";
                        break;
                    end
                end
                e = ext_of(cfg_start_ext);
            end
        end
    end

    // stimulus and directed checks
    initial begin : stim
        wait (cycles_done >= 1);
        @(posedge clk); #1;
        pattern = 17'h0F00F;
        cfg_start_ext = 3'd1;
        wait (cycles_done >= 2);
        @(posedge clk); #1;
        cfg_frames = 5'd0;
        cfg_start_ext = 3'd7;
        pattern = '1;
        wait (cycles_done >= 3);
        @(negedge clk);
        chk("R5", "irq_vec with frames=0", int'(irq_vec), 32'h1);
        @(posedge clk); #1;
        cfg_frames = 5'd31;
        pattern = 17'h10001;
        wait (cycles_done >= 4);
        @(negedge clk);
        chk("R5", "irq_vec with frames=31", int'(irq_vec), 32'h10001);
        @(posedge clk); #1;
        cfg_frames = 5'd5;
        noise = 1;
        pattern = 17'h00005;
        wait (cycles_done >= 5);
        @(negedge clk);
        chk("R10", "irq_vec under noise", int'(irq_vec), 32'h5);
        @(posedge clk); #1;
        noise = 0;
        cfg_frames = 5'd17;
        cfg_quiet = 1'b1;
        pattern = 17'h0A0A1;
        wait (cycles_done >= 6);
        repeat (12) @(posedge clk);
        #1;
        cfg_start_ext = 3'd5;
        pattern = 17'h13579;
        req_periph = 1;
        wait (req_periph == 0);
        @(posedge clk); #1;
        req_periph = 1;
        wait (cycles_done >= 8);
        repeat (6) @(posedge clk);
        #1;
        cfg_quiet = 1'b0;
        pattern = 17'h0C3C3;
        wait (cycles_done >= 10);
        @(negedge clk);
        chk("R8", "drv_en during continuous start", int'(drv_en), 1);
        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog R1 actual=hung expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule